// File: doc/BRIEF.md
# Multi-Port Circular Instruction Buffer

This block sits between an instruction fetch path and the instruction grouping logic. Each clock it can take in a fetch group of one to four instructions and, in the same clock, hand on up to four of the oldest instructions it holds. The two sides move independently, so the buffer absorbs short fetch bubbles and short issue stalls without losing the four-per-cycle rate.

Storage is a twelve-entry ring addressed by a read pointer and a write pointer. Both pointers wrap modulo twelve, and an occupancy counter tells a full ring from an empty one. The fetch side sees a ready flag that is high only while at least four entries are free, so any fetch group offered while ready is taken whole. The issue side sees the four oldest entries, a valid bit per slot, and an available count. Downstream returns a consume count for the same cycle. A flush input empties the ring in one clock.

Top module: `insn_ring_buf`

## Requirements
- R1: Synchronous active-high reset leaves the ring empty: issue_avail is 0, issue_valid is 0 and fetch_rdy is 1 on the first cycle after reset.
- R2: fetch_rdy is 1 exactly when the number of free entries (12 minus the held count) is at least 4.
- R3: When fetch_rdy is 1 and fetch_cnt is N in 1..4, lanes 0..N-1 of fetch_insn (lane k in bits [32k+31:32k]) are appended in lane order behind the held instructions at the next clock.
- R4: A fetch offered while fetch_rdy is 0 is dropped: the held count and held instructions do not change because of it.
- R5: A fetch_cnt value of 5, 6 or 7 is handled as 4.
- R6: Issue slot k (bits [32k+31:32k] of issue_insn) presents the k-th oldest held instruction; issue_valid[k] is 1 only when k is less than the held count, and issue_avail equals the smaller of the held count and 4.
- R7: issue_take is limited to issue_avail; a take larger than that, including any take while empty, removes only the available entries.
- R8: A fetch and a take in the same cycle both apply: the next held count is the old count minus the limited take plus the accepted fetch count.
- R9: First-in first-out order is kept across any number of pointer wraps on the 12-entry ring.
- R10: flush empties the ring at the next clock and drops any fetch group and take given in the same cycle.
- R11: An issue slot whose valid bit is 0 drives all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the ring at the next clock |
| fetch_cnt | input | 3 | Number of instructions offered this cycle (0..4, above 4 treated as 4) |
| fetch_insn | input | 128 | Four instruction lanes, lane 0 oldest |
| fetch_rdy | output | 1 | At least four entries are free |
| issue_avail | output | 3 | Number of valid issue slots (0..4) |
| issue_insn | output | 128 | Four oldest held instructions, slot 0 oldest |
| issue_valid | output | 4 | Per-slot valid bits |
| issue_take | input | 3 | Number of slots consumed this cycle |

## Verification
The bench aims at the ring boundary: a ring filled to twelve, a fetch offered while not ready, and long random runs that wrap both pointers many times; a design with a power-of-two wrap or a lost full/empty distinction would deliver stale or repeated instructions there. Takes larger than the held count and takes on an empty ring are driven, which would underflow the count and corrupt the read pointer in a design that skips the limit. Flush is driven together with a fetch, which a design that lets the write through would leave partly filled, and oversized fetch counts are offered to catch a design that writes past lane 3.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

  // Advance a ring index by inc places; inc never exceeds depth.
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned inc,
                                           input int unsigned depth);
    int unsigned sum;
    sum = base + inc;
    return (sum >= depth) ? (sum - depth) : sum;
  endfunction

  // Smaller of two counts.
  function automatic int unsigned cnt_min(input int unsigned a,
                                          input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl #(
  parameter int DEPTH = 12,
  parameter int LANES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic [$clog2(LANES+1)-1:0]     fetch_cnt,
  input  logic [$clog2(LANES+1)-1:0]     take_cnt,
  output logic                           fetch_rdy,
  output logic [$clog2(LANES+1)-1:0]     avail,
  output logic [$clog2(LANES+1)-1:0]     wr_num,
  output logic [$clog2(DEPTH)-1:0]       wptr,
  output logic [$clog2(DEPTH)-1:0]       rptr,
  output logic [$clog2(DEPTH+1)-1:0]     occ
);
  import ibuf_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int NW = $clog2(LANES+1);

  logic [NW-1:0] rd_num;
  int unsigned   occ_i;

  always_comb begin
    occ_i     = int'(occ);
    fetch_rdy = (DEPTH - occ_i) >= LANES;
    avail     = NW'(cnt_min(occ_i, LANES));
    rd_num    = NW'(cnt_min(int'(take_cnt), int'(avail)));
    if (flush || !fetch_rdy)
      wr_num = '0;
    else
      wr_num = NW'(cnt_min(int'(fetch_cnt), LANES));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rptr <= '0;
      wptr <= '0;
      occ  <= '0;
    end else begin
      rptr <= PW'(ring_add(int'(rptr), int'(rd_num), DEPTH));
      wptr <= PW'(ring_add(int'(wptr), int'(wr_num), DEPTH));
      occ  <= CW'(occ_i - int'(rd_num) + int'(wr_num));
    end
  end

  // R4: the held count never exceeds the ring size
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  // R9: pointer distance agrees with the held count, modulo the ring size
  a_r9_ptr_gap: assert property (@(posedge clk) disable iff (rst)
    ((int'(wptr) + DEPTH - int'(rptr)) % DEPTH) == (int'(occ) % DEPTH));

  // R9: pointers stay inside the ring
  a_r9_ptr_range: assert property (@(posedge clk) disable iff (rst)
    (int'(wptr) < DEPTH) && (int'(rptr) < DEPTH));

  // R10: flush empties the ring at the next clock
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0) && (rptr == wptr));

  // R8: with no take and no accepted fetch the ring holds still
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!flush && take_cnt == '0 && (fetch_cnt == '0 || !fetch_rdy))
      |=> $stable(occ) && $stable(rptr) && $stable(wptr));

  // R7: a take on an empty ring with no fetch leaves it empty
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && fetch_cnt == '0) |=> (occ == '0));

endmodule

// File: rtl/ibuf_store.sv
module ibuf_store #(
  parameter int DEPTH = 12,
  parameter int LANES = 4,
  parameter int IW    = 32
) (
  input  logic                       clk,
  input  logic [$clog2(DEPTH)-1:0]   wptr,
  input  logic [$clog2(LANES+1)-1:0] wr_num,
  input  logic [LANES*IW-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0]   rptr,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  output logic [LANES*IW-1:0]        rd_data,
  output logic [LANES-1:0]           rd_valid
);
  import ibuf_pkg::*;

  localparam int PW = $clog2(DEPTH);

  logic [IW-1:0] ring_q [DEPTH];

  // Write side: lane k lands at wptr + k when k is below the accepted count.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(wr_num))
        ring_q[PW'(ring_add(int'(wptr), k, DEPTH))] <= wr_data[k*IW +: IW];
    end
  end

  // Read side: slot k shows rptr + k, zeroed when past the held count.
  for (genvar k = 0; k < LANES; k++) begin : g_slot
    logic [PW-1:0] idx;
    assign idx              = PW'(ring_add(int'(rptr), k, DEPTH));
    assign rd_valid[k]      = k < int'(occ);
    assign rd_data[k*IW +: IW] = rd_valid[k] ? ring_q[idx] : '0;
  end

endmodule

// File: rtl/insn_ring_buf.sv
module insn_ring_buf #(
  parameter int DEPTH = 12,
  parameter int LANES = 4,
  parameter int IW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [$clog2(LANES+1)-1:0] fetch_cnt,
  input  logic [LANES*IW-1:0]        fetch_insn,
  output logic                       fetch_rdy,
  output logic [$clog2(LANES+1)-1:0] issue_avail,
  output logic [LANES*IW-1:0]        issue_insn,
  output logic [LANES-1:0]           issue_valid,
  input  logic [$clog2(LANES+1)-1:0] issue_take
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int NW = $clog2(LANES+1);

  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  logic [NW-1:0] wr_num;

  ibuf_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fetch_cnt (fetch_cnt),
    .take_cnt  (issue_take),
    .fetch_rdy (fetch_rdy),
    .avail     (issue_avail),
    .wr_num    (wr_num),
    .wptr      (wptr),
    .rptr      (rptr),
    .occ       (occ)
  );

  ibuf_store #(.DEPTH(DEPTH), .LANES(LANES), .IW(IW)) store_i (
    .clk      (clk),
    .wptr     (wptr),
    .wr_num   (wr_num),
    .wr_data  (fetch_insn),
    .rptr     (rptr),
    .occ      (occ),
    .rd_data  (issue_insn),
    .rd_valid (issue_valid)
  );

  // R6: the available count matches the number of valid slots
  a_r6_avail_valid: assert property (@(posedge clk) disable iff (rst)
    $countones(issue_valid) == int'(issue_avail));

  // R6: valid slots form a run starting at slot 0
  a_r6_valid_run: assert property (@(posedge clk) disable iff (rst)
    ((issue_valid + 1'b1) & issue_valid) == '0);

  // R2: not ready means fewer than LANES entries free, so nothing is written
  a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    !fetch_rdy |-> (wr_num == '0));

endmodule

// File: tb/insn_ring_buf_tb_top.sv
`timescale 1ns/1ps
module insn_ring_buf_tb_top;

  localparam int DEPTH = 12;
  localparam int LANES = 4;
  localparam int IW    = 32;
  localparam int NW    = 3;

  logic                clk = 1'b0;
  logic                rst;
  logic                flush;
  logic [NW-1:0]       fetch_cnt;
  logic [LANES*IW-1:0] fetch_insn;
  logic                fetch_rdy;
  logic [NW-1:0]       issue_avail;
  logic [LANES*IW-1:0] issue_insn;
  logic [LANES-1:0]    issue_valid;
  logic [NW-1:0]       issue_take;

  always #2 clk = ~clk;

  insn_ring_buf #(.DEPTH(DEPTH), .LANES(LANES), .IW(IW)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .fetch_cnt(fetch_cnt),
    .fetch_insn(fetch_insn), .fetch_rdy(fetch_rdy),
    .issue_avail(issue_avail), .issue_insn(issue_insn),
    .issue_valid(issue_valid), .issue_take(issue_take)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference ring
  logic [IW-1:0] mdl [DEPTH];
  int m_head = 0;
  int m_cnt  = 0;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    int av;
    logic [LANES-1:0] v;
    av = imin(m_cnt, LANES);
    v  = '0;
    for (int k = 0; k < LANES; k++) if (k < m_cnt) v[k] = 1'b1;
    chk("R2", {tag, " fetch_rdy"}, longint'(fetch_rdy), longint'((DEPTH - m_cnt) >= LANES));
    chk("R6", {tag, " issue_avail"}, longint'(issue_avail), longint'(av));
    chk("R6", {tag, " issue_valid"}, longint'(issue_valid), longint'(v));
    for (int k = 0; k < LANES; k++) begin
      if (k < m_cnt)
        chk("R3", {tag, " slot data"}, longint'(issue_insn[k*IW +: IW]),
            longint'(mdl[(m_head + k) % DEPTH]));
      else
        chk("R11", {tag, " idle slot zero"}, longint'(issue_insn[k*IW +: IW]), 0);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check at the next falling edge.
  task automatic step(input bit fl, input int cnt, input int take, input string tag);
    int t, n;
    flush      = fl;
    fetch_cnt  = NW'(cnt);
    issue_take = NW'(take);
    for (int k = 0; k < LANES; k++) fetch_insn[k*IW +: IW] = $urandom;
    @(posedge clk);
    if (fl) begin
      m_head = 0;
      m_cnt  = 0;
    end else begin
      t = imin(take, imin(m_cnt, LANES));
      n = ((DEPTH - m_cnt) >= LANES) ? imin(cnt, LANES) : 0;
      for (int k = 0; k < n; k++)
        mdl[(m_head + m_cnt + k) % DEPTH] = fetch_insn[k*IW +: IW];
      m_head = (m_head + t) % DEPTH;
      m_cnt  = m_cnt - t + n;
    end
    @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; flush = 1'b0; fetch_cnt = '0; issue_take = '0; fetch_insn = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "avail", longint'(issue_avail), 0);
    chk("R1", "valid", longint'(issue_valid), 0);
    chk("R1", "fetch_rdy", longint'(fetch_rdy), 1);

    // R3: fill to capacity with whole groups
    step(0, 4, 0, "R3 fill1");
    step(0, 4, 0, "R3 fill2");
    step(0, 4, 0, "R3 fill3");
    chk("R2", "full ready low", longint'(fetch_rdy), 0);
    // R4: fetch while not ready is dropped
    step(0, 4, 0, "R4 drop");
    chk("R4", "avail after drop", longint'(issue_avail), 4);
    // R7: oversized take limited to 4
    step(0, 0, 7, "R7 clamp");
    chk("R7", "ready after take", longint'(fetch_rdy), 1);
    // R5 + R8: fetch count 6 treated as 4 with a same-cycle take of 2 -> 10 held
    step(0, 6, 2, "R5 R8 mixed");
    step(0, 0, 4, "R8 drain a");
    step(0, 0, 4, "R8 drain b");
    chk("R8", "two left", longint'(issue_avail), 2);
    // R10: flush drops a same-cycle fetch
    step(0, 4, 0, "R10 prefill");
    step(1, 3, 1, "R10 flush");
    chk("R10", "avail after flush", longint'(issue_avail), 0);
    // R7: take on empty ring
    step(0, 0, 3, "R7 empty take");
    chk("R7", "still empty", longint'(issue_valid), 0);
    // R11: partial fill leaves upper slots zero
    step(0, 2, 0, "R11 partial");
    chk("R11", "slot3 zero", longint'(issue_insn[3*IW +: IW]), 0);

    // R9: random traffic wrapping the pointers many times
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 64) == 0, int'($urandom % 8), int'($urandom % 8), "R9 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule